// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block carries out the architectural state changes a CPU core makes when it enters a synchronous exception or a debug exception. The core presents an exception request with a cause code and the PC of the faulting instruction. It can also present a faulting virtual address, a debug request and a debug cause code. In the same cycle the block answers with a taken pulse and the redirect PC. At the following clock edge it commits the saved PC, the saved status, the cause registers and the new processor status.

The block owns the processor status word, a saved-PC register for each interrupt level, a saved-status register for each level from 2 upward, a general cause register, a faulting-address register, a debug cause register, an optional double-exception PC register and the vector-base register. A small special-register port reads and writes all of them.

A general exception is routed to one of three vectors: user, kernel or double. A debug exception is routed to the debug vector. Each vector can be moved by the vector-base register.

Top module: `exc_entry_ctrl`

## Requirements
- R1: `taken` and `target_pc` are combinational. `taken` is high in the same cycle as an accepted request and low when no request is accepted.
- R2: A general exception with the exception-mode status bit (bit 4) clear writes `fault_pc` to the level-1 saved PC. It selects the user vector when the user-mode bit (bit 5) is set and the kernel vector when that bit is clear.
- R3: A general exception with exception mode already set selects the double vector, whatever the user-mode bit holds. The PC goes to the double-exception PC register when `HAS_DPC` is 1 and to the level-1 saved PC otherwise.
- R4: Every general exception writes `exc_cause` to the cause register and sets exception mode. All other status bits are left unchanged.
- R5: The faulting-address register loads `fault_vaddr` only on a general exception that has `addr_valid` high. It keeps its value otherwise.
- R6: An accepted debug exception does all of the following: it writes `dbg_cause` to the debug cause register, writes the PC to saved PC[`DBG_LEVEL`], writes the old status to saved status[`DBG_LEVEL`], sets the interrupt-level field (bits 3:0) to `DBG_LEVEL`, sets exception mode and selects the debug vector.
- R7: A debug request is accepted only while the interrupt-level field is below `DBG_LEVEL`. A rejected debug request changes nothing, and a general request in the same cycle proceeds as though the debug request were absent.
- R8: When a debug request is accepted together with a general request, the debug request wins. The general cause and the faulting-address registers keep their values.
- R9: With `RELOC_EN`=1, the target is the default vector minus `DEFAULT_BASE` plus the vector-base register. With `RELOC_EN`=0, the target is the default vector unchanged.
- R10: The special-register addresses are: 0x00 status, 0x01 cause, 0x02 faulting address, 0x03 debug cause, 0x04 vector base, 0x05 double-exception PC, 0x10+L saved PC of level L, and 0x20+L saved status of level L. Reads are combinational. Reset clears every register except the vector base, which resets to `DEFAULT_BASE`.
- R11: When a port write and an exception update hit the same register in one cycle, the exception update wins, computed from the old register value. A port write to a register that the exception does not touch still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | General exception request |
| exc_cause | input | 6 | General cause code |
| fault_pc | input | 32 | PC of the faulting instruction (used for both exception kinds) |
| addr_valid | input | 1 | A faulting virtual address accompanies the request |
| fault_vaddr | input | 32 | Faulting virtual address |
| dbg_req | input | 1 | Debug exception request |
| dbg_cause | input | 6 | Debug cause code |
| sr_we | input | 1 | Special-register write enable |
| sr_addr | input | 6 | Special-register address |
| sr_wdata | input | 32 | Special-register write data |
| sr_rdata | output | 32 | Special-register read data |
| taken | output | 1 | Exception accepted this cycle |
| target_pc | output | 32 | Redirect PC |

## Verification
The main entry path is driven with status words that cover each combination of exception mode and user mode. This shows whether the kernel, user and double vectors are each chosen from the correct bit, and whether the user-mode bit is ignored once exception mode is set. Debug requests are applied at interrupt levels below, equal to and above the debug level, both alone and together with a general request. These cases expose the acceptance threshold, the priority between the two request kinds and which registers the losing request must leave untouched. A non-default vector base separates relocated targets from fixed ones. A second instance with relocation and the double-exception PC register both disabled covers the other variant. Same-cycle port writes show which update wins.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int XLEN   = 32;
    localparam int CAUSE_W = 6;
    localparam int SRA_W  = 6;
    localparam int ILVL_W = 4;

    typedef logic [XLEN-1:0]    word_t;
    typedef logic [CAUSE_W-1:0] cause_t;
    typedef logic [SRA_W-1:0]   sraddr_t;

    typedef enum logic [2:0] {
        K_NONE   = 3'd0,
        K_KERNEL = 3'd1,
        K_USER   = 3'd2,
        K_DOUBLE = 3'd3,
        K_DEBUG  = 3'd4
    } kind_e;

    localparam sraddr_t SR_STATUS   = 6'h00;
    localparam sraddr_t SR_CAUSE    = 6'h01;
    localparam sraddr_t SR_VADDR    = 6'h02;
    localparam sraddr_t SR_DBGCAUSE = 6'h03;
    localparam sraddr_t SR_VECBASE  = 6'h04;
    localparam sraddr_t SR_DBLPC    = 6'h05;
    localparam sraddr_t SR_SPC_BASE = 6'h10;
    localparam sraddr_t SR_SPS_BASE = 6'h20;

    function automatic word_t relocate(word_t vec, word_t dflt_base, word_t vb, bit en);
        return en ? (vec - dflt_base + vb) : vec;
    endfunction

    function automatic logic is_general(kind_e k);
        return (k == K_KERNEL) || (k == K_USER) || (k == K_DOUBLE);
    endfunction
endpackage

// File: rtl/exc_decide.sv
module exc_decide
    import exc_pkg::*;
#(
    parameter int    DBG_LEVEL    = 6,
    parameter int    ILVL_LSB     = 0,
    parameter int    EXCM_POS     = 4,
    parameter int    UM_POS       = 5,
    parameter bit    RELOC_EN     = 1'b1,
    parameter word_t DEFAULT_BASE = 32'h4000_0000,
    parameter word_t VEC_KERNEL   = 32'h4000_0300,
    parameter word_t VEC_USER     = 32'h4000_0340,
    parameter word_t VEC_DOUBLE   = 32'h4000_03C0,
    parameter word_t VEC_DEBUG    = 32'h4000_0280
) (
    input  word_t status,
    input  word_t vecbase,
    input  logic  exc_req,
    input  logic  dbg_req,
    output kind_e kind,
    output word_t target
);
    localparam logic [ILVL_W-1:0] DBG_LVL = ILVL_W'(DBG_LEVEL);

    logic [ILVL_W-1:0] cur_lvl;
    logic              dbg_ok;
    word_t             dflt_vec;

    assign cur_lvl = status[ILVL_LSB +: ILVL_W];
    assign dbg_ok  = dbg_req && (cur_lvl < DBG_LVL);

    always_comb begin
        if (dbg_ok)
            kind = K_DEBUG;
        else if (exc_req) begin
            if (status[EXCM_POS])    kind = K_DOUBLE;
            else if (status[UM_POS]) kind = K_USER;
            else                     kind = K_KERNEL;
        end else
            kind = K_NONE;
    end

    always_comb begin
        unique case (kind)
            K_KERNEL: dflt_vec = VEC_KERNEL;
            K_USER:   dflt_vec = VEC_USER;
            K_DOUBLE: dflt_vec = VEC_DOUBLE;
            K_DEBUG:  dflt_vec = VEC_DEBUG;
            default:  dflt_vec = DEFAULT_BASE;
        endcase
    end

    assign target = relocate(dflt_vec, DEFAULT_BASE, vecbase, RELOC_EN);
endmodule

// File: rtl/exc_sr_file.sv
module exc_sr_file
    import exc_pkg::*;
#(
    parameter int    NLEVELS      = 7,
    parameter int    DBG_LEVEL    = 6,
    parameter bit    HAS_DPC      = 1'b1,
    parameter int    ILVL_LSB     = 0,
    parameter int    EXCM_POS     = 4,
    parameter word_t DEFAULT_BASE = 32'h4000_0000
) (
    input  logic    clk,
    input  logic    rst,
    input  kind_e   kind,
    input  word_t   pc,
    input  cause_t  exc_cause,
    input  logic    addr_valid,
    input  word_t   fault_vaddr,
    input  cause_t  dbg_cause,
    input  logic    sr_we,
    input  sraddr_t sr_addr,
    input  word_t   sr_wdata,
    output word_t   status_q,
    output cause_t  cause_q,
    output word_t   vecbase_q,
    output word_t   dpc_q,
    output word_t   sr_rdata
);
    logic  gen_exc, dbg_exc, dbl_to_dpc;
    word_t status_dbg;
    word_t vaddr_q;
    cause_t dbgc_q;
    logic [NLEVELS:1][XLEN-1:0] spc_all;
    logic [NLEVELS:1][XLEN-1:0] sps_all;

    assign gen_exc    = is_general(kind);
    assign dbg_exc    = (kind == K_DEBUG);
    assign dbl_to_dpc = HAS_DPC && (kind == K_DOUBLE);

    always_comb begin
        status_dbg = status_q;
        status_dbg[ILVL_LSB +: ILVL_W] = ILVL_W'(DBG_LEVEL);
        status_dbg[EXCM_POS] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                                    status_q <= '0;
        else if (dbg_exc)                           status_q <= status_dbg;
        else if (gen_exc)                           status_q <= status_q | (word_t'(1) << EXCM_POS);
        else if (sr_we && sr_addr == SR_STATUS)     status_q <= sr_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)                                    cause_q <= '0;
        else if (gen_exc)                           cause_q <= exc_cause;
        else if (sr_we && sr_addr == SR_CAUSE)      cause_q <= sr_wdata[CAUSE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)                                    vaddr_q <= '0;
        else if (gen_exc && addr_valid)             vaddr_q <= fault_vaddr;
        else if (sr_we && sr_addr == SR_VADDR)      vaddr_q <= sr_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)                                    dbgc_q <= '0;
        else if (dbg_exc)                           dbgc_q <= dbg_cause;
        else if (sr_we && sr_addr == SR_DBGCAUSE)   dbgc_q <= sr_wdata[CAUSE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)                                    vecbase_q <= DEFAULT_BASE;
        else if (sr_we && sr_addr == SR_VECBASE)    vecbase_q <= sr_wdata;
    end

    generate
        if (HAS_DPC) begin : g_dpc
            word_t q;
            always_ff @(posedge clk) begin
                if (rst)                                q <= '0;
                else if (dbl_to_dpc)                    q <= pc;
                else if (sr_we && sr_addr == SR_DBLPC)  q <= sr_wdata;
            end
            assign dpc_q = q;
        end else begin : g_no_dpc
            assign dpc_q = '0;
        end
    endgenerate

    generate
        for (genvar l = 1; l <= NLEVELS; l++) begin : g_spc
            localparam sraddr_t ADDR = SR_SPC_BASE + sraddr_t'(l);
            logic  save_now;
            word_t q;
            if (l == 1) begin : g_l1
                assign save_now = (gen_exc && !dbl_to_dpc) || (dbg_exc && DBG_LEVEL == 1);
            end else begin : g_ln
                assign save_now = dbg_exc && (DBG_LEVEL == l);
            end
            always_ff @(posedge clk) begin
                if (rst)                            q <= '0;
                else if (save_now)                  q <= pc;
                else if (sr_we && sr_addr == ADDR)  q <= sr_wdata;
            end
            assign spc_all[l] = q;
        end

        assign sps_all[1] = '0;
        for (genvar l = 2; l <= NLEVELS; l++) begin : g_sps
            localparam sraddr_t ADDR = SR_SPS_BASE + sraddr_t'(l);
            word_t q;
            always_ff @(posedge clk) begin
                if (rst)                                  q <= '0;
                else if (dbg_exc && DBG_LEVEL == l)       q <= status_q;
                else if (sr_we && sr_addr == ADDR)        q <= sr_wdata;
            end
            assign sps_all[l] = q;
        end
    endgenerate

    always_comb begin
        sr_rdata = '0;
        case (sr_addr)
            SR_STATUS:   sr_rdata = status_q;
            SR_CAUSE:    sr_rdata = XLEN'(cause_q);
            SR_VADDR:    sr_rdata = vaddr_q;
            SR_DBGCAUSE: sr_rdata = XLEN'(dbgc_q);
            SR_VECBASE:  sr_rdata = vecbase_q;
            SR_DBLPC:    sr_rdata = dpc_q;
            default:     sr_rdata = '0;
        endcase
        for (int l = 1; l <= NLEVELS; l++) begin
            if (sr_addr == SR_SPC_BASE + sraddr_t'(l)) sr_rdata = spc_all[l];
        end
        for (int l = 2; l <= NLEVELS; l++) begin
            if (sr_addr == SR_SPS_BASE + sraddr_t'(l)) sr_rdata = sps_all[l];
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int    NLEVELS      = 7,
    parameter int    DBG_LEVEL    = 6,
    parameter bit    HAS_DPC      = 1'b1,
    parameter bit    RELOC_EN     = 1'b1,
    parameter int    ILVL_LSB     = 0,
    parameter int    EXCM_POS     = 4,
    parameter int    UM_POS       = 5,
    parameter word_t DEFAULT_BASE = 32'h4000_0000,
    parameter word_t VEC_KERNEL   = 32'h4000_0300,
    parameter word_t VEC_USER     = 32'h4000_0340,
    parameter word_t VEC_DOUBLE   = 32'h4000_03C0,
    parameter word_t VEC_DEBUG    = 32'h4000_0280
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        exc_req,
    input  logic [5:0]  exc_cause,
    input  logic [31:0] fault_pc,
    input  logic        addr_valid,
    input  logic [31:0] fault_vaddr,
    input  logic        dbg_req,
    input  logic [5:0]  dbg_cause,
    input  logic        sr_we,
    input  logic [5:0]  sr_addr,
    input  logic [31:0] sr_wdata,
    output logic [31:0] sr_rdata,
    output logic        taken,
    output logic [31:0] target_pc
);
    kind_e  kind;
    word_t  status_q;
    word_t  vecbase_q;
    word_t  dpc_q;
    cause_t cause_q;

    exc_decide #(
        .DBG_LEVEL(DBG_LEVEL), .ILVL_LSB(ILVL_LSB), .EXCM_POS(EXCM_POS),
        .UM_POS(UM_POS), .RELOC_EN(RELOC_EN), .DEFAULT_BASE(DEFAULT_BASE),
        .VEC_KERNEL(VEC_KERNEL), .VEC_USER(VEC_USER),
        .VEC_DOUBLE(VEC_DOUBLE), .VEC_DEBUG(VEC_DEBUG)
    ) u_decide (
        .status (status_q),
        .vecbase(vecbase_q),
        .exc_req(exc_req),
        .dbg_req(dbg_req),
        .kind   (kind),
        .target (target_pc)
    );

    exc_sr_file #(
        .NLEVELS(NLEVELS), .DBG_LEVEL(DBG_LEVEL), .HAS_DPC(HAS_DPC),
        .ILVL_LSB(ILVL_LSB), .EXCM_POS(EXCM_POS), .DEFAULT_BASE(DEFAULT_BASE)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .kind       (kind),
        .pc         (fault_pc),
        .exc_cause  (exc_cause),
        .addr_valid (addr_valid),
        .fault_vaddr(fault_vaddr),
        .dbg_cause  (dbg_cause),
        .sr_we      (sr_we),
        .sr_addr    (sr_addr),
        .sr_wdata   (sr_wdata),
        .status_q   (status_q),
        .cause_q    (cause_q),
        .vecbase_q  (vecbase_q),
        .dpc_q      (dpc_q),
        .sr_rdata   (sr_rdata)
    );

    assign taken = (kind != K_NONE);
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int DBG_LEVEL = 6,
    parameter int ILVL_LSB  = 0,
    parameter int EXCM_POS  = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        exc_req,
    input logic [5:0]  exc_cause,
    input logic        dbg_req,
    input logic        sr_we,
    input logic        taken,
    input logic [31:0] status_q,
    input logic [5:0]  cause_q
);
    localparam logic [3:0] DL = 4'(DBG_LEVEL);
    logic [3:0] lvl;
    assign lvl = status_q[ILVL_LSB +: 4];

    assert_no_req_no_take_R1: assert property (@(posedge clk) disable iff (rst)
        (!exc_req && !dbg_req) |-> !taken);

    assert_excm_after_take_R4: assert property (@(posedge clk) disable iff (rst)
        taken |=> status_q[EXCM_POS]);

    assert_cause_written_R4: assert property (@(posedge clk) disable iff (rst)
        (exc_req && !dbg_req) |=> (cause_q == $past(exc_cause)));

    assert_dbg_level_R6: assert property (@(posedge clk) disable iff (rst)
        (dbg_req && lvl < DL) |=> (lvl == DL));

    assert_dbg_reject_R7: assert property (@(posedge clk) disable iff (rst)
        (dbg_req && !exc_req && lvl >= DL) |-> !taken);

    assert_dbg_priority_R8: assert property (@(posedge clk) disable iff (rst)
        (dbg_req && exc_req && lvl < DL && !sr_we) |=> $stable(cause_q));

    assert_status_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (!taken && !sr_we) |=> $stable(status_q));
endmodule

bind exc_entry_ctrl exc_entry_chk #(
    .DBG_LEVEL(DBG_LEVEL), .ILVL_LSB(ILVL_LSB), .EXCM_POS(EXCM_POS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .exc_req  (exc_req),
    .exc_cause(exc_cause),
    .dbg_req  (dbg_req),
    .sr_we    (sr_we),
    .taken    (taken),
    .status_q (status_q),
    .cause_q  (cause_q)
);

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
    localparam logic [31:0] BASE  = 32'h4000_0000;
    localparam logic [31:0] V_KER = 32'h4000_0300;
    localparam logic [31:0] V_USR = 32'h4000_0340;
    localparam logic [31:0] V_DBL = 32'h4000_03C0;
    localparam logic [31:0] V_DBG = 32'h4000_0280;
    localparam int DL = 6;

    logic clk = 0, rst = 1;
    always #4 clk = ~clk;

    logic        exc_req = 0, addr_valid = 0, dbg_req = 0, sr_we = 0;
    logic [5:0]  exc_cause = 0, dbg_cause = 0, sr_addr = 0;
    logic [31:0] fault_pc = 0, fault_vaddr = 0, sr_wdata = 0;
    logic [31:0] sr_rdata, target_pc;
    logic        taken;

    logic        a_exc_req = 0, a_we = 0;
    logic [5:0]  a_addr = 0;
    logic [31:0] a_pc = 0, a_wdata = 0, a_rdata, a_target;
    logic        a_taken;

    exc_entry_ctrl #(.DBG_LEVEL(DL), .HAS_DPC(1'b1), .RELOC_EN(1'b1), .DEFAULT_BASE(BASE),
        .VEC_KERNEL(V_KER), .VEC_USER(V_USR), .VEC_DOUBLE(V_DBL), .VEC_DEBUG(V_DBG)
    ) u_exc_entry_ctrl (
        .clk(clk), .rst(rst), .exc_req(exc_req), .exc_cause(exc_cause), .fault_pc(fault_pc),
        .addr_valid(addr_valid), .fault_vaddr(fault_vaddr), .dbg_req(dbg_req),
        .dbg_cause(dbg_cause), .sr_we(sr_we), .sr_addr(sr_addr), .sr_wdata(sr_wdata),
        .sr_rdata(sr_rdata), .taken(taken), .target_pc(target_pc));

    exc_entry_ctrl #(.DBG_LEVEL(DL), .HAS_DPC(1'b0), .RELOC_EN(1'b0), .DEFAULT_BASE(BASE),
        .VEC_KERNEL(V_KER), .VEC_USER(V_USR), .VEC_DOUBLE(V_DBL), .VEC_DEBUG(V_DBG)
    ) u_exc_entry_ctrl_alt (
        .clk(clk), .rst(rst), .exc_req(a_exc_req), .exc_cause(6'h07), .fault_pc(a_pc),
        .addr_valid(1'b0), .fault_vaddr(32'h0), .dbg_req(1'b0),
        .dbg_cause(6'h0), .sr_we(a_we), .sr_addr(a_addr), .sr_wdata(a_wdata),
        .sr_rdata(a_rdata), .taken(a_taken), .target_pc(a_target));

    int checks = 0, fails = 0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic sr_wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); sr_we = 1; sr_addr = a; sr_wdata = d;
        @(negedge clk); sr_we = 0;
    endtask

    task automatic sr_rd(input logic [5:0] a, output logic [31:0] d);
        sr_addr = a; #1; d = sr_rdata;
    endtask

    typedef struct packed {
        logic [31:0] ps;
        logic [31:0] vb;
        logic        gen;
        logic        dbg;
        logic        av;
    } vec_t;

    localparam vec_t TBL [0:7] = '{
        '{ps: 32'h0000_0000, vb: 32'h4000_0000, gen: 1, dbg: 0, av: 1},
        '{ps: 32'h0000_0020, vb: 32'h8000_0000, gen: 1, dbg: 0, av: 0},
        '{ps: 32'h0000_0010, vb: 32'h4000_0000, gen: 1, dbg: 0, av: 1},
        '{ps: 32'h0000_0030, vb: 32'h1000_0000, gen: 1, dbg: 0, av: 0},
        '{ps: 32'h0000_0103, vb: 32'h2000_0000, gen: 0, dbg: 1, av: 0},
        '{ps: 32'h0000_0007, vb: 32'h4000_0000, gen: 1, dbg: 1, av: 1},
        '{ps: 32'h0000_0025, vb: 32'h3000_0000, gen: 1, dbg: 1, av: 1},
        '{ps: 32'h0000_0026, vb: 32'h4000_0000, gen: 0, dbg: 1, av: 0}
    };

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd, m_vaddr, exp_t, exp_ps, pc;
        logic [5:0]  m_cause, m_dbgc;
        logic        dok;
        int          kind;
        m_vaddr = 0; m_cause = 0; m_dbgc = 0;

        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10 reset values, R1 idle
        sr_rd(6'h00, rd); chk("R10 reset status", rd, 32'h0);
        sr_rd(6'h04, rd); chk("R10 reset vecbase", rd, BASE);
        sr_rd(6'h01, rd); chk("R10 reset cause", rd, 32'h0);
        chk("R1 idle taken", {31'b0, taken}, 32'h0);

        for (int i = 0; i < 8; i++) begin
            vec_t e;
            e = TBL[i];
            pc = 32'h1000_0000 + 32'(i) * 32'h10;
            sr_wr(6'h00, e.ps);
            sr_wr(6'h04, e.vb);
            dok = e.dbg && (e.ps[3:0] < 4'(DL));
            if (dok) kind = 4;
            else if (e.gen) kind = e.ps[4] ? 3 : (e.ps[5] ? 2 : 1);
            else kind = 0;
            case (kind)
                1: exp_t = V_KER - BASE + e.vb;
                2: exp_t = V_USR - BASE + e.vb;
                3: exp_t = V_DBL - BASE + e.vb;
                4: exp_t = V_DBG - BASE + e.vb;
                default: exp_t = 32'h0;
            endcase
            exc_req = e.gen; dbg_req = e.dbg; addr_valid = e.av;
            exc_cause = 6'(i + 8); dbg_cause = 6'(i + 32);
            fault_pc = pc; fault_vaddr = 32'hA000_0000 + 32'(i);
            #1;
            chk("R1 R7 taken", {31'b0, taken}, {31'b0, kind != 0});
            if (kind != 0) chk("R2 R3 R6 R9 target", target_pc, exp_t);
            @(negedge clk);
            exc_req = 0; dbg_req = 0; addr_valid = 0;
            if (kind == 4) begin
                exp_ps = (e.ps & ~32'hF) | 32'(DL) | 32'h10;
                m_dbgc = 6'(i + 32);
            end else if (kind != 0) begin
                exp_ps = e.ps | 32'h10;
                m_cause = 6'(i + 8);
                if (e.av) m_vaddr = 32'hA000_0000 + 32'(i);
            end else exp_ps = e.ps;
            sr_rd(6'h00, rd); chk("R4 R6 R7 status", rd, exp_ps);
            sr_rd(6'h01, rd); chk("R4 R8 cause", rd, 32'(m_cause));
            sr_rd(6'h02, rd); chk("R5 vaddr", rd, m_vaddr);
            sr_rd(6'h03, rd); chk("R6 R7 dbgcause", rd, 32'(m_dbgc));
            if (kind == 4) begin
                sr_rd(6'h16, rd); chk("R6 saved pc", rd, pc);
                sr_rd(6'h26, rd); chk("R6 saved status", rd, e.ps);
            end else if (kind == 3) begin
                sr_rd(6'h05, rd); chk("R3 double pc", rd, pc);
            end else if (kind != 0) begin
                sr_rd(6'h11, rd); chk("R2 level1 pc", rd, pc);
            end
        end

        // R11: port write to status and cause collides with exception
        sr_wr(6'h00, 32'h0);
        @(negedge clk);
        sr_we = 1; sr_addr = 6'h00; sr_wdata = 32'h0000_0020;
        exc_req = 1; exc_cause = 6'h05; fault_pc = 32'h5555_0000;
        @(negedge clk);
        sr_we = 0; exc_req = 0;
        sr_rd(6'h00, rd); chk("R11 status exception wins", rd, 32'h10);
        sr_rd(6'h11, rd); chk("R11 level1 pc", rd, 32'h5555_0000);
        @(negedge clk);
        sr_we = 1; sr_addr = 6'h01; sr_wdata = 32'h3F;
        exc_req = 1; exc_cause = 6'h09;
        @(negedge clk);
        sr_we = 0; exc_req = 0;
        sr_rd(6'h01, rd); chk("R11 cause exception wins", rd, 32'h09);
        @(negedge clk);
        sr_we = 1; sr_addr = 6'h03; sr_wdata = 32'h2A;
        exc_req = 1; exc_cause = 6'h0B;
        @(negedge clk);
        sr_we = 0; exc_req = 0;
        sr_rd(6'h03, rd); chk("R11 untouched reg written", rd, 32'h2A);

        // R7 boundary: level equal to debug level rejects, no general request
        sr_wr(6'h00, 32'(DL));
        dbg_req = 1; dbg_cause = 6'h11; #1;
        chk("R7 reject at level", {31'b0, taken}, 32'h0);
        @(negedge clk); dbg_req = 0;
        sr_rd(6'h03, rd); chk("R7 dbgcause kept", rd, 32'h2A);
        sr_rd(6'h00, rd); chk("R7 status kept", rd, 32'(DL));

        // R9 and R3 on the variant without relocation and double PC register
        @(negedge clk); a_we = 1; a_addr = 6'h04; a_wdata = 32'h8000_0000;
        @(negedge clk); a_addr = 6'h00; a_wdata = 32'h10;
        @(negedge clk); a_we = 0; a_exc_req = 1; a_pc = 32'h7777_0000; #1;
        chk("R9 fixed double target", a_target, V_DBL);
        @(negedge clk); a_exc_req = 0;
        a_addr = 6'h11; #1; chk("R3 level1 pc without dpc", a_rdata, 32'h7777_0000);
        a_addr = 6'h05; #1; chk("R3 no dpc reads zero", a_rdata, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule